// File: doc/BRIEF.md
# Eight-Channel Output Protection and Diagnostic Supervisor

This block sits on the power side of an isolated output stage. It produces the final gate enables for eight high-side switches. Each enable combines four things: the on/off command word received over the isolation link, a thermal shutdown state kept for each channel, a supply undervoltage state shared by all channels, and two gating conditions. The first gating condition is link health. The second is a flag from the logic side that says it has settled. The block also drives one shared active-low diagnostic line.

Each channel uses two comparator flags, one for "above trip" and one for "below restart", to form its own hysteresis latch. A hot channel switches itself off and comes back by itself once it has cooled. The other channels are not affected. The supply uses the same kind of latch, built from a "below shutdown" flag and an "above restart" flag. A transfer strobe is marked either good or bad. Bad transfers in a row are counted, and at a configurable limit (four by default) every output is forced off until a good transfer arrives.

Top module: `chan_guard`

## Requirements
- R1: When `temp_trip[i]` is high at a clock edge, channel i enters thermal-off. Its `gate_en[i]` is low one cycle later. No other channel's thermal state changes.
- R2: A thermal-off channel returns to run when `temp_clear[i]` is high and `temp_trip[i]` is low. If both flags are high, the trip wins. If both are low, the state is held.
- R3: The supply latch enters supply-off when `vsup_low` is high and leaves it when only `vsup_ok` is high. If both are high, `vsup_low` wins. While supply-off is set, all gates are low.
- R4: `diag_n` is low exactly when any channel is thermal-off or supply-off holds, and it follows that state with a one-cycle delay.
- R5: A good transfer (`xfer_stb`=1, `xfer_good`=1) loads `xfer_data` into the command word. Bit i controls channel i, where 1 means on.
- R6: A bad transfer (`xfer_stb`=1, `xfer_good`=0) leaves the command word unchanged and adds one to the run of consecutive bad transfers. Once that run reaches FAIL_LIMIT (4), all gates are forced low.
- R7: A good transfer sets the bad-transfer run back to zero, which lifts the forced-off condition in the same cycle as the new command.
- R8: While `src_stable` is low, all gates are low. The command word is kept, so the gates come back when `src_stable` returns high.
- R9: `gate_en` is registered and equals command AND NOT thermal-off AND NOT supply-off AND link-ok AND `src_stable`, all evaluated from the states the same edge produces.
- R10: After synchronous reset, `gate_en` is 0 and `diag_n` is 0. The command word, the bad-transfer run and every thermal state are cleared, and supply-off is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_stb | input | 1 | A transfer from the isolation link completes this cycle |
| xfer_good | input | 1 | The completing transfer is valid |
| xfer_data | input | N_CH | Command word carried by the transfer |
| temp_trip | input | N_CH | Per-channel junction above trip point |
| temp_clear | input | N_CH | Per-channel junction below restart point |
| vsup_low | input | 1 | Output supply below shutdown level |
| vsup_ok | input | 1 | Output supply above restart level |
| src_stable | input | 1 | Logic-side domain reports a stable state |
| gate_en | output | N_CH | Registered gate enables |
| diag_n | output | 1 | Registered active-low shared diagnostic |

## Verification
Each output is a register computed from the states that the same edge writes. As a result, every stimulus presented before edge k shows up on `gate_en` and `diag_n` right after edge k, one cycle later, and the bench holds to that timing. The bench drives inputs on the falling edge and updates its own reference model right away. It then waits for the next falling edge and compares the outputs against the model, so each comparison falls exactly one edge after its stimulus. The directed checks for thermal trip, supply hysteresis, the fourth bad transfer and loss of source stability read the outputs at that same falling edge and compare them with literal values.

// File: rtl/cg_pkg.sv
package cg_pkg;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_OFF = 1'b1
  } hys_state_t;

  // Set/reset hysteresis step: the set (shutdown) side dominates.
  function automatic hys_state_t hys_next(input hys_state_t cur,
                                          input logic set_off,
                                          input logic clr_off);
    hys_state_t n;
    if (set_off)      n = ST_OFF;
    else if (clr_off) n = ST_RUN;
    else              n = cur;
    return n;
  endfunction

endpackage

// File: rtl/cg_thermal_cell.sv
module cg_thermal_cell
  import cg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic clear,
  output logic off_q,
  output logic off_nxt
);

  hys_state_t st_q, st_d;

  always_comb st_d = hys_next(st_q, trip, clear);

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RUN;
    else     st_q <= st_d;
  end

  assign off_q   = (st_q == ST_OFF);
  assign off_nxt = (st_d == ST_OFF);

  assert_trip_off_R1: assert property (@(posedge clk) disable iff (rst)
    trip |=> off_q);

  assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (!trip && clear) |=> !off_q);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!trip && !clear) |=> (off_q == $past(off_q)));

endmodule

// File: rtl/cg_supply_mon.sv
module cg_supply_mon
  import cg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vlow,
  input  logic vok,
  output logic off_q,
  output logic off_nxt
);

  hys_state_t st_q, st_d;

  always_comb st_d = hys_next(st_q, vlow, vok);

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_OFF;
    else     st_q <= st_d;
  end

  assign off_q   = (st_q == ST_OFF);
  assign off_nxt = (st_d == ST_OFF);

  assert_low_wins_R3: assert property (@(posedge clk) disable iff (rst)
    vlow |=> off_q);

  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (vok && !vlow) |=> !off_q);

endmodule

// File: rtl/cg_link_watch.sv
module cg_link_watch #(
  parameter int N_CH       = 8,
  parameter int FAIL_LIMIT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic            good,
  input  logic [N_CH-1:0] data,
  output logic [N_CH-1:0] cmd_q,
  output logic [N_CH-1:0] cmd_nxt,
  output logic            link_ok_nxt
);

  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FAIL_LIMIT);

  logic [CNT_W-1:0] bad_q, bad_d;

  always_comb begin
    bad_d   = bad_q;
    cmd_nxt = cmd_q;
    if (stb && good) begin
      bad_d   = '0;
      cmd_nxt = data;
    end else if (stb && (bad_q < LIMIT)) begin
      bad_d = bad_q + 1'b1;
    end
  end

  assign link_ok_nxt = (bad_d < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q <= '0;
      cmd_q <= '0;
    end else begin
      bad_q <= bad_d;
      cmd_q <= cmd_nxt;
    end
  end

  assert_bad_bound_R6: assert property (@(posedge clk) disable iff (rst)
    bad_q <= LIMIT);

  assert_cmd_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (stb && !good) |=> $stable(cmd_q));

  assert_good_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (stb && good) |=> (bad_q == '0) && (cmd_q == $past(data)));

endmodule

// File: rtl/chan_guard.sv
module chan_guard #(
  parameter int N_CH       = 8,
  parameter int FAIL_LIMIT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xfer_stb,
  input  logic            xfer_good,
  input  logic [N_CH-1:0] xfer_data,
  input  logic [N_CH-1:0] temp_trip,
  input  logic [N_CH-1:0] temp_clear,
  input  logic            vsup_low,
  input  logic            vsup_ok,
  input  logic            src_stable,
  output logic [N_CH-1:0] gate_en,
  output logic            diag_n
);

  logic [N_CH-1:0] th_off_q, th_off_nxt;
  logic [N_CH-1:0] cmd_q, cmd_nxt;
  logic            sup_off_q, sup_off_nxt;
  logic            link_ok_nxt;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    cg_thermal_cell u_th (
      .clk    (clk),
      .rst    (rst),
      .trip   (temp_trip[i]),
      .clear  (temp_clear[i]),
      .off_q  (th_off_q[i]),
      .off_nxt(th_off_nxt[i])
    );
  end

  cg_supply_mon u_sup (
    .clk    (clk),
    .rst    (rst),
    .vlow   (vsup_low),
    .vok    (vsup_ok),
    .off_q  (sup_off_q),
    .off_nxt(sup_off_nxt)
  );

  cg_link_watch #(.N_CH(N_CH), .FAIL_LIMIT(FAIL_LIMIT)) u_link (
    .clk        (clk),
    .rst        (rst),
    .stb        (xfer_stb),
    .good       (xfer_good),
    .data       (xfer_data),
    .cmd_q      (cmd_q),
    .cmd_nxt    (cmd_nxt),
    .link_ok_nxt(link_ok_nxt)
  );

  logic            allow_all;
  logic [N_CH-1:0] gate_d;

  always_comb begin
    allow_all = !sup_off_nxt && link_ok_nxt && src_stable;
    gate_d    = allow_all ? (cmd_nxt & ~th_off_nxt) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en <= '0;
      diag_n  <= 1'b0;
    end else begin
      gate_en <= gate_d;
      diag_n  <= !((|th_off_nxt) || sup_off_nxt);
    end
  end

  assert_diag_low_R4: assert property (@(posedge clk) disable iff (rst)
    ((|th_off_q) || sup_off_q) |-> !diag_n);

  assert_diag_high_R4: assert property (@(posedge clk) disable iff (rst)
    (!(|th_off_q) && !sup_off_q) |-> diag_n);

  assert_gate_vs_thermal_R9: assert property (@(posedge clk) disable iff (rst)
    (gate_en & th_off_q) == '0);

  assert_gate_vs_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    (gate_en & ~cmd_q) == '0);

  assert_supply_gates_R3: assert property (@(posedge clk) disable iff (rst)
    sup_off_q |-> (gate_en == '0));

  assert_stable_gates_R8: assert property (@(posedge clk) disable iff (rst)
    (gate_en != '0) |-> $past(src_stable));

endmodule

// File: tb/chan_guard_tb.sv
module chan_guard_tb;

  localparam int N = 8;
  localparam int LIM = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         xfer_stb = 1'b0, xfer_good = 1'b0;
  logic [N-1:0] xfer_data = '0, temp_trip = '0, temp_clear = '0;
  logic         vsup_low = 1'b0, vsup_ok = 1'b0, src_stable = 1'b0;
  logic [N-1:0] gate_en;
  logic         diag_n;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [N-1:0] m_th = '0;
  logic         m_uv = 1'b1;
  logic [N-1:0] m_cmd = '0;
  int           m_bad = 0;
  logic [N-1:0] e_gate = '0;
  logic         e_diag = 1'b0;

  always #4 clk = ~clk;

  chan_guard #(.N_CH(N), .FAIL_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .xfer_stb(xfer_stb), .xfer_good(xfer_good),
    .xfer_data(xfer_data), .temp_trip(temp_trip), .temp_clear(temp_clear),
    .vsup_low(vsup_low), .vsup_ok(vsup_ok), .src_stable(src_stable),
    .gate_en(gate_en), .diag_n(diag_n)
  );

  function automatic logic [N-1:0] model_gate(input logic [N-1:0] cmd,
      input logic [N-1:0] th, input logic uv, input int bad, input logic st);
    if (uv || bad >= LIM || !st) return '0;
    return cmd & ~th;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, step the model, compare at the next falling edge.
  task automatic apply(input logic v, input logic g, input logic [N-1:0] d,
                       input logic [N-1:0] tr, input logic [N-1:0] cl,
                       input logic lo, input logic ok, input logic st);
    xfer_stb = v; xfer_good = g; xfer_data = d;
    temp_trip = tr; temp_clear = cl;
    vsup_low = lo; vsup_ok = ok; src_stable = st;
    for (int i = 0; i < N; i++) begin
      if (tr[i])      m_th[i] = 1'b1;
      else if (cl[i]) m_th[i] = 1'b0;
    end
    if (lo)      m_uv = 1'b1;
    else if (ok) m_uv = 1'b0;
    if (v && g) begin
      m_cmd = d; m_bad = 0;
    end else if (v && m_bad < LIM) begin
      m_bad++;
    end
    e_gate = model_gate(m_cmd, m_th, m_uv, m_bad, st);
    e_diag = !((|m_th) || m_uv);
    @(negedge clk);
    chk("R9 gate model", gate_en, e_gate);
    chk("R4 diag model", {7'd0, diag_n}, {7'd0, e_diag});
  endtask

  task automatic idle();
    apply(1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset values before any edge without reset
    chk("R10 gate reset", gate_en, '0);
    chk("R10 diag reset", {7'd0, diag_n}, 8'd0);

    // R3: supply restart
    apply(1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b1, 1'b1);
    chk("R3 diag after supply ok", {7'd0, diag_n}, 8'd1);
    // R5: load command
    apply(1'b1, 1'b1, 8'hA5, '0, '0, 1'b0, 1'b0, 1'b1);
    chk("R5 load", gate_en, 8'hA5);
    // R1: trip channel 0
    apply(1'b0, 1'b0, '0, 8'h01, '0, 1'b0, 1'b0, 1'b1);
    chk("R1 trip ch0", gate_en, 8'hA4);
    chk("R4 diag on trip", {7'd0, diag_n}, 8'd0);
    // R2: both flags: trip wins; hold; then restart
    apply(1'b0, 1'b0, '0, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1);
    chk("R2 trip dominates", gate_en, 8'hA4);
    idle();
    chk("R2 hold off", gate_en, 8'hA4);
    apply(1'b0, 1'b0, '0, '0, 8'h01, 1'b0, 1'b0, 1'b1);
    chk("R2 restart", gate_en, 8'hA5);
    chk("R4 diag clear", {7'd0, diag_n}, 8'd1);
    // R6: three bad transfers keep command, fourth forces off
    for (int k = 0; k < LIM - 1; k++) begin
      apply(1'b1, 1'b0, 8'hFF, '0, '0, 1'b0, 1'b0, 1'b1);
      chk("R6 bad kept", gate_en, 8'hA5);
    end
    apply(1'b1, 1'b0, 8'hFF, '0, '0, 1'b0, 1'b0, 1'b1);
    chk("R6 forced off", gate_en, 8'h00);
    idle();
    chk("R6 stays off", gate_en, 8'h00);
    // R7: good transfer restores
    apply(1'b1, 1'b1, 8'h3C, '0, '0, 1'b0, 1'b0, 1'b1);
    chk("R7 recover", gate_en, 8'h3C);
    // R8: source not stable
    apply(1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0);
    chk("R8 unstable off", gate_en, 8'h00);
    idle();
    chk("R8 command kept", gate_en, 8'h3C);
    // R3: undervoltage, low dominates
    apply(1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b1);
    chk("R3 uv off", gate_en, 8'h00);
    chk("R3 uv diag", {7'd0, diag_n}, 8'd0);
    apply(1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b1, 1'b1);
    chk("R3 low dominates", gate_en, 8'h00);
    apply(1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b1, 1'b1);
    chk("R3 uv restart", gate_en, 8'h3C);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      logic v, g, lo, ok, st;
      logic [N-1:0] d, tr, cl;
      v  = ($urandom % 3) == 0;
      g  = ($urandom % 5) > 1;
      d  = N'($urandom);
      tr = '0; cl = '0;
      for (int i = 0; i < N; i++) begin
        tr[i] = ($urandom % 24) == 0;
        cl[i] = ($urandom % 4) == 0;
      end
      lo = ($urandom % 40) == 0;
      ok = ($urandom % 4) == 0;
      st = ($urandom % 25) != 0;
      apply(v, g, d, tr, cl, lo, ok, st);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule